// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a 14-bit virtual address into a physical address through a small on-chip table of four segments. The two top address bits pick a segment and the low twelve bits are an offset into it. Each table entry holds a base, a limit, an in-use flag and three permission bits for read, write and execute. A request also carries its access type, which is fetch, load or store. The block returns either the physical address or a fault code that gives the cause.

The translation path is combinational from the table registers. One request is accepted every cycle. An optional output register, parameter `OUT_REG` (on by default), adds one cycle of latency. A single privileged write port loads table entries or the table-length register. A write without the privilege flag changes nothing and raises an error pulse.

Top module: `seg_xlat`

## Requirements
- R1: The segment number is `req_addr[13:12]` and the offset is `req_addr[11:0]`. When no fault applies, `rsp_paddr` equals the segment base plus the zero-extended offset and `rsp_fault` is 2'b00.
- R2: An offset equal to or greater than the segment limit gives `rsp_fault` = 2'b10 (bounds). On any fault `rsp_paddr` is zero.
- R3: Permission bits are bit0 read, bit1 write and bit2 execute. `req_acc` 2'b00 (fetch) needs execute, 2'b01 (load) needs read, and 2'b10 or 2'b11 (store) needs write. A missing bit gives `rsp_fault` = 2'b11. A read-only code segment therefore allows fetch and load and faults on store.
- R4: A segment whose in-use flag is clear gives `rsp_fault` = 2'b01 (invalid segment).
- R5: A segment number equal to or greater than the table length gives `rsp_fault` = 2'b01, even when the entry is marked in use.
- R6: When more than one cause applies, invalid segment wins over bounds, and bounds wins over permission.
- R7: A table write with `wr_priv` low leaves the table and the length unchanged. It drives `wr_err` high for the one cycle after the write cycle. `wr_len_sel` high writes `wr_length` into the table length, and low writes the entry chosen by `wr_idx`.
- R8: After reset every entry is invalid and the table length is zero, so every request faults with 2'b01.
- R9: With `OUT_REG` = 1 the response for a request appears one cycle later, and `rsp_valid` follows `req_valid` with that same delay.
- R10: A request and a table write in the same cycle use the table contents from before the write. The write takes effect for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 14 | Virtual address |
| req_acc | input | 2 | Access type: 00 fetch, 01 load, 1x store |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 16 | Physical address, zero on fault |
| rsp_fault | output | 2 | 00 none, 01 invalid, 10 bounds, 11 permission |
| wr_en | input | 1 | Table write strobe |
| wr_priv | input | 1 | Writer is privileged |
| wr_len_sel | input | 1 | 1 writes the table length, 0 writes an entry |
| wr_idx | input | 2 | Entry index for an entry write |
| wr_base | input | 16 | Entry base |
| wr_limit | input | 13 | Entry limit in bytes |
| wr_perm | input | 3 | Entry permission bits {x,w,r} |
| wr_valid | input | 1 | Entry in-use flag |
| wr_length | input | 3 | New table length (0 to 4) |
| wr_err | output | 1 | Pulse after an unprivileged write |

## Verification
The two functions that can share a cycle are a table update and a translation that reads the same entry. The bench provokes this by rebasing segment 1 in the same cycle as a request to 0x1108. It expects the response to carry the old base, and a second request to carry the new one. A second overlap checks that an unprivileged write issued with a request leaves that request's result unchanged and also raises `wr_err`.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_INVAL = 2'b01,
        FLT_BOUND = 2'b10,
        FLT_PERM  = 2'b11
    } fault_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'b00,
        ACC_LOAD  = 2'b01,
        ACC_STORE = 2'b10,
        ACC_STALT = 2'b11
    } acc_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

    function automatic logic perm_allows(input logic [2:0] perm, input logic [1:0] acc);
        logic ok;
        case (acc)
            2'b00:   ok = perm[PERM_X];
            2'b01:   ok = perm[PERM_R];
            default: ok = perm[PERM_W];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int NSEG     = 4,
    parameter int SEG_BITS = 2,
    parameter int PA_W     = 16,
    parameter int LIM_W    = 13,
    localparam int LEN_W   = SEG_BITS + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                wr_priv,
    input  logic                wr_len_sel,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [LIM_W-1:0]    wr_limit,
    input  logic [2:0]          wr_perm,
    input  logic                wr_valid,
    input  logic [LEN_W-1:0]    wr_length,
    output logic [PA_W-1:0]     base_q  [NSEG],
    output logic [LIM_W-1:0]    limit_q [NSEG],
    output logic [2:0]          perm_q  [NSEG],
    output logic                used_q  [NSEG],
    output logic [LEN_W-1:0]    length_q,
    output logic                wr_err
);

    logic ok_wr;
    assign ok_wr = wr_en && wr_priv;

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                perm_q[g]  <= '0;
                used_q[g]  <= 1'b0;
            end else if (ok_wr && !wr_len_sel && wr_idx == SEG_BITS'(g)) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                perm_q[g]  <= wr_perm;
                used_q[g]  <= wr_valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            length_q <= '0;
            wr_err   <= 1'b0;
        end else begin
            if (ok_wr && wr_len_sel) length_q <= wr_length;
            wr_err <= wr_en && !wr_priv;
        end
    end

    // R7
    unpriv_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_priv) |=> wr_err);

    // R7
    unpriv_len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_priv) |=> $stable(length_q));

    // R8
    reset_len_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (length_q == '0 && !wr_err));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int NSEG     = 4,
    parameter int SEG_BITS = 2,
    parameter int OFF_W    = 12,
    parameter int PA_W     = 16,
    parameter int LIM_W    = 13,
    localparam int LEN_W   = SEG_BITS + 1,
    localparam int VA_W    = SEG_BITS + OFF_W
) (
    input  logic [VA_W-1:0]  addr,
    input  logic [1:0]       acc,
    input  logic [PA_W-1:0]  base_q  [NSEG],
    input  logic [LIM_W-1:0] limit_q [NSEG],
    input  logic [2:0]       perm_q  [NSEG],
    input  logic             used_q  [NSEG],
    input  logic [LEN_W-1:0] length_q,
    output fault_e           fault,
    output logic [PA_W-1:0]  paddr
);

    logic [SEG_BITS-1:0] seg;
    logic [OFF_W-1:0]    off;
    logic                bad_seg, over, denied;

    assign seg = addr[VA_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];

    always_comb begin
        bad_seg = !used_q[seg] || (LEN_W'(seg) >= length_q);
        over    = LIM_W'(off) >= limit_q[seg];
        denied  = !perm_allows(perm_q[seg], acc);
        if (bad_seg)     fault = FLT_INVAL;
        else if (over)   fault = FLT_BOUND;
        else if (denied) fault = FLT_PERM;
        else             fault = FLT_NONE;
        paddr = (fault == FLT_NONE) ? base_q[seg] + PA_W'(off) : '0;
    end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
    import seg_xlat_pkg::*;
#(
    parameter bit OUT_REG = 1'b1,
    parameter int PA_W    = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  fault_e          in_fault,
    input  logic [PA_W-1:0] in_paddr,
    output logic            out_valid,
    output fault_e          out_fault,
    output logic [PA_W-1:0] out_paddr
);

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_fault <= FLT_NONE;
                out_paddr <= '0;
            end else begin
                out_valid <= in_valid;
                out_fault <= in_fault;
                out_paddr <= in_paddr;
            end
        end

        // R9
        latency_chk: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_fault = in_fault;
        assign out_paddr = in_paddr;
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_BITS = 2,
    parameter int OFF_W    = 12,
    parameter int PA_W     = 16,
    parameter bit OUT_REG  = 1'b1,
    localparam int NSEG    = 1 << SEG_BITS,
    localparam int VA_W    = SEG_BITS + OFF_W,
    localparam int LIM_W   = OFF_W + 1,
    localparam int LEN_W   = SEG_BITS + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_addr,
    input  logic [1:0]          req_acc,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_paddr,
    output logic [1:0]          rsp_fault,
    input  logic                wr_en,
    input  logic                wr_priv,
    input  logic                wr_len_sel,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [LIM_W-1:0]    wr_limit,
    input  logic [2:0]          wr_perm,
    input  logic                wr_valid,
    input  logic [LEN_W-1:0]    wr_length,
    output logic                wr_err
);

    logic [PA_W-1:0]  base_q  [NSEG];
    logic [LIM_W-1:0] limit_q [NSEG];
    logic [2:0]       perm_q  [NSEG];
    logic             used_q  [NSEG];
    logic [LEN_W-1:0] length_q;
    fault_e           c_fault, o_fault;
    logic [PA_W-1:0]  c_paddr;

    seg_table #(.NSEG(NSEG), .SEG_BITS(SEG_BITS), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_len_sel(wr_len_sel), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm), .wr_valid(wr_valid),
        .wr_length(wr_length),
        .base_q(base_q), .limit_q(limit_q), .perm_q(perm_q), .used_q(used_q),
        .length_q(length_q), .wr_err(wr_err)
    );

    seg_check #(.NSEG(NSEG), .SEG_BITS(SEG_BITS), .OFF_W(OFF_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
        .addr(req_addr), .acc(req_acc),
        .base_q(base_q), .limit_q(limit_q), .perm_q(perm_q), .used_q(used_q),
        .length_q(length_q), .fault(c_fault), .paddr(c_paddr)
    );

    seg_out_stage #(.OUT_REG(OUT_REG), .PA_W(PA_W)) u_out (
        .clk(clk), .rst(rst),
        .in_valid(req_valid), .in_fault(c_fault), .in_paddr(c_paddr),
        .out_valid(rsp_valid), .out_fault(o_fault), .out_paddr(rsp_paddr)
    );

    assign rsp_fault = o_fault;

    // R2
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault != 2'b00) |-> (rsp_paddr == '0));

    // R4
    unused_seg_chk: assert property (@(posedge clk) disable iff (rst)
        (!used_q[req_addr[VA_W-1:OFF_W]]) |-> (c_fault == FLT_INVAL));

    // R5
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        (LEN_W'(req_addr[VA_W-1:OFF_W]) >= length_q) |-> (c_fault == FLT_INVAL));

endmodule

// File: tb/seg_xlat_tb.sv
module seg_xlat_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [13:0] req_addr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        wr_en = 1'b0, wr_priv = 1'b0, wr_len_sel = 1'b0, wr_valid = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [15:0] wr_base = '0;
    logic [12:0] wr_limit = '0;
    logic [2:0]  wr_perm = '0;
    logic [2:0]  wr_length = '0;
    logic        wr_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    seg_xlat u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .wr_en(wr_en), .wr_priv(wr_priv), .wr_len_sel(wr_len_sel), .wr_idx(wr_idx),
        .wr_base(wr_base), .wr_limit(wr_limit), .wr_perm(wr_perm), .wr_valid(wr_valid),
        .wr_length(wr_length), .wr_err(wr_err)
    );

    // {addr, acc, fault, paddr}; acc 0 fetch 1 load 2 store
    localparam int NV = 14;
    localparam logic [33:0] VEC [NV] = '{
        {14'h0240, 2'd1, 2'd0, 16'h4240},   // R1
        {14'h0240, 2'd0, 2'd0, 16'h4240},   // R3 fetch on code
        {14'h0240, 2'd2, 2'd3, 16'h0000},   // R3 store on code
        {14'h1108, 2'd1, 2'd0, 16'h0108},   // R1
        {14'h1108, 2'd2, 2'd0, 16'h0108},   // R3 store on data
        {14'h1108, 2'd0, 2'd3, 16'h0000},   // R3 fetch on data
        {14'h1600, 2'd1, 2'd2, 16'h0000},   // R2
        {14'h265c, 2'd1, 2'd1, 16'h0000},   // R4
        {14'h3002, 2'd2, 2'd0, 16'h2002},   // R1
        {14'h3fff, 2'd1, 2'd0, 16'h2fff},   // R2 last byte
        {14'h06ff, 2'd1, 2'd0, 16'h46ff},   // R2 last byte
        {14'h0700, 2'd1, 2'd2, 16'h0000},   // R2 limit
        {14'h0800, 2'd2, 2'd2, 16'h0000},   // R6 bounds over perm
        {14'h1500, 2'd0, 2'd2, 16'h0000}    // R6 bounds over perm
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic twrite(input bit priv, input bit lsel, input logic [1:0] idx,
                          input logic [15:0] b, input logic [12:0] l, input logic [2:0] p,
                          input bit v, input logic [2:0] len);
        @(negedge clk);
        wr_en = 1'b1; wr_priv = priv; wr_len_sel = lsel; wr_idx = idx;
        wr_base = b; wr_limit = l; wr_perm = p; wr_valid = v; wr_length = len;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic xlat(input string req, input logic [13:0] a, input logic [1:0] acc,
                        input logic [1:0] ef, input logic [15:0] ep);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {30'd0, rsp_fault}, {30'd0, ef});
        check(req, {16'd0, rsp_paddr}, {16'd0, ep});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8 reset state
        check("R8 wr_err", {31'd0, wr_err}, 32'd0);
        xlat("R8", 14'h0240, 2'd1, 2'd1, 16'h0);
        xlat("R8", 14'h3002, 2'd1, 2'd1, 16'h0);

        // table load: perm {x,w,r}
        twrite(1, 0, 2'd0, 16'h4000, 13'h0700, 3'b101, 1, 3'd0);
        twrite(1, 0, 2'd1, 16'h0000, 13'h0500, 3'b011, 1, 3'd0);
        twrite(1, 0, 2'd3, 16'h2000, 13'h1000, 3'b011, 1, 3'd0);
        // R5 length still zero
        xlat("R5", 14'h0240, 2'd1, 2'd1, 16'h0);
        twrite(1, 1, 2'd0, 16'h0, 13'h0, 3'b0, 0, 3'd4);

        for (int i = 0; i < NV; i++) begin
            xlat("R1/R2/R3/R4/R6 vector", VEC[i][33:20], VEC[i][19:18], VEC[i][17:16], VEC[i][15:0]);
        end

        // R6 invalid over bounds: seg2 unused, offset beyond any limit
        xlat("R6", 14'h2fff, 2'd2, 2'd1, 16'h0);

        // R9 valid tracking
        @(negedge clk);
        req_valid = 1'b1; req_addr = 14'h0240; req_acc = 2'd1;
        check("R9 no early", {31'd0, rsp_valid}, 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 valid", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        check("R9 drop", {31'd0, rsp_valid}, 32'd0);

        // R7 unprivileged entry write ignored, error pulses once
        @(negedge clk);
        wr_en = 1'b1; wr_priv = 1'b0; wr_len_sel = 1'b0; wr_idx = 2'd2;
        wr_base = 16'h7000; wr_limit = 13'h1000; wr_perm = 3'b111; wr_valid = 1'b1;
        req_valid = 1'b1; req_addr = 14'h0240; req_acc = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R7 err", {31'd0, wr_err}, 32'd1);
        check("R7 same-cycle req", {16'd0, rsp_paddr}, 32'h4240);
        @(negedge clk);
        check("R7 err pulse", {31'd0, wr_err}, 32'd0);
        xlat("R7 entry unchanged", 14'h2010, 2'd1, 2'd1, 16'h0);
        // R7 unprivileged length write
        twrite(0, 1, 2'd0, 16'h0, 13'h0, 3'b0, 0, 3'd1);
        xlat("R7 length unchanged", 14'h3002, 2'd1, 2'd0, 16'h2002);

        // R10 rebase segment 1 in same cycle as request
        @(negedge clk);
        wr_en = 1'b1; wr_priv = 1'b1; wr_len_sel = 1'b0; wr_idx = 2'd1;
        wr_base = 16'h0100; wr_limit = 13'h0500; wr_perm = 3'b011; wr_valid = 1'b1;
        req_valid = 1'b1; req_addr = 14'h1108; req_acc = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R10 old base", {16'd0, rsp_paddr}, 32'h0108);
        xlat("R10 new base", 14'h1108, 2'd1, 2'd0, 16'h0208);

        // R5 shrink length to 3, seg3 still marked in use
        twrite(1, 1, 2'd0, 16'h0, 13'h0, 3'b0, 0, 3'd3);
        xlat("R5", 14'h3002, 2'd1, 2'd1, 16'h0);
        xlat("R5 in range", 14'h1000, 2'd1, 2'd0, 16'h0100);

        // R4 clear in-use flag of segment 0
        twrite(1, 0, 2'd0, 16'h4000, 13'h0700, 3'b101, 0, 3'd0);
        xlat("R4", 14'h0240, 2'd1, 2'd1, 16'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule